// File: doc/BRIEF.md
# S/PDIF Receiver Control and Status Block

This block holds the software-visible control side of an S/PDIF receiver. A host reaches it over a simple 32-bit memory-mapped bus with separate read and write strobes. The block keeps the control word, the interrupt mask, the sticky status flags, the latest data word and the latest channel-status word. It also runs the enable state machine and raises a single interrupt line. The biphase decoder is not part of this block. The decoder reports events to it as one-cycle pulses and takes back two run signals: one tells it to hunt for sync, the other tells it to deliver samples.

The state machine has five states. In IDLE the decoder is off. In WAIT_ACT the block waits for line activity before it allows a sync attempt. In SYNC the decoder is hunting for sync. In LOCKED sync has been found, but the control word does not yet ask for reception. In RECV samples flow. The transitions are as follows. IDLE goes to WAIT_ACT when the enable field turns non-zero with the wait bit set. IDLE goes to SYNC when the enable field turns non-zero with the wait bit clear. WAIT_ACT goes to SYNC on an activity pulse. SYNC goes to LOCKED on a sync-done pulse. LOCKED goes to RECV when the enable field is 11. RECV goes back to LOCKED when the enable field stops being 11. Every state goes to IDLE when the enable field is 00.

Top module: `sprx_regs`

## Requirements
- R1: After reset, every register reads zero, the state is IDLE, and `irq`, `dec_sync_go` and `dec_rx_go` are low.
- R2: The enable field is bits 1:0 of the control word at offset 0x00. The value 00 means idle, 01 means sync only and 11 means reception (10 behaves like 01). `dec_sync_go` is high only in SYNC. `dec_rx_go` is high only in RECV, and RECV is reached only after a sync-done pulse while the field is 11.
- R3: Bit 14 of the control word selects wait-for-activity. When it is set, leaving IDLE enters WAIT_ACT. In WAIT_ACT, `dec_sync_go` stays low and decoder error pulses are ignored until `ev_activity` pulses, after which the state is SYNC.
- R4: Status is read at offset 0x08. The bits are: 0 data ready, 1 channel-status ready, 2 parity, 3 overrun, 4 sync block, 5 sync done, 6 frame error, 7 sync error, 8 timeout. An event pulse in SYNC, LOCKED or RECV sets its bit at the next clock edge, and the bit stays set. Event pulses in IDLE or WAIT_ACT are ignored.
- R5: Writing to offset 0x0C clears status bits 2 to 5 wherever the written bit is 1. Written zeros have no effect. An event arriving in the same cycle as its clear keeps the bit set.
- R6: A `dec_word_vld` pulse in RECV captures `dec_word` and sets bit 0. Only a read of offset 0x10 clears bit 0; writes to 0x0C do not touch bits 0, 1 or 6 to 8.
- R7: A `dec_cs_vld` pulse in RECV captures `dec_cs_word` and sets bit 1. A read of offset 0x14 returns that word and clears bit 1.
- R8: When the enable field is 00, the block returns to IDLE on the next edge and clears status bits 6 to 8. Those bits do not clear through offset 0x0C.
- R9: The mask is bits 6:0 at offset 0x04. `irq` is the OR of status bits 0 to 5 each ANDed with the same-numbered mask bit, plus mask bit 6 ANDed with the OR of status bits 6 to 8.
- R10: The status word is read-only, and writes to it are ignored. Offset 0x18 returns the `dec_thresh` input. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers clear-on-read) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| ev_sync_done | input | 1 | Decoder pulse: sync achieved |
| ev_sync_blk | input | 1 | Decoder pulse: block start seen |
| ev_parity | input | 1 | Decoder pulse: parity error |
| ev_overrun | input | 1 | Decoder pulse: overrun |
| ev_frame_err | input | 1 | Decoder pulse: frame error |
| ev_sync_err | input | 1 | Decoder pulse: sync error |
| ev_timeout | input | 1 | Decoder pulse: timeout |
| ev_activity | input | 1 | Decoder pulse: line transitions seen |
| dec_word | input | DATA_W | Decoded sample word |
| dec_word_vld | input | 1 | `dec_word` valid pulse |
| dec_cs_word | input | DATA_W | Channel-status/user word |
| dec_cs_vld | input | 1 | `dec_cs_word` valid pulse |
| dec_thresh | input | DATA_W | Pulse-width thresholds, read at 0x18 |
| dec_sync_go | output | 1 | Decoder should hunt for sync |
| dec_rx_go | output | 1 | Decoder should deliver samples |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the places where flags can be lost or cleared wrongly. It checks that an error pulse during WAIT_ACT leaves no flag, which a design that ignored the wait bit would fail by recording a false sync error. It checks that a flag-clear write of all ones leaves data-ready and the three error bits alone, so a design that cleared too wide would drop them. It checks that a clear and an event in the same cycle keep the bit, so a design giving the clear priority would lose the event. It checks that the single grouped mask bit raises `irq` for a timeout and that disabling wipes the error bits, which a per-bit mask decode or a missing disable-clear would get wrong.

// File: rtl/sprx_pkg.sv
package sprx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_ACT,
        ST_SYNC,
        ST_LOCKED,
        ST_RECV
    } sprx_state_e;

    localparam int NUM_FLAGS = 9;
    localparam int FL_DATA   = 0;
    localparam int FL_CS     = 1;
    localparam int W1C_LO    = 2;
    localparam int W1C_HI    = 5;
    localparam int ERR_LO    = 6;
    localparam int ERR_HI    = 8;
    localparam int MASK_W    = 7;
    localparam int MASK_GRP  = 6;
    localparam int EN_W      = 2;
    localparam int CTRL_WFA  = 14;

    localparam int OFS_CTRL = 'h00;
    localparam int OFS_MASK = 'h04;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_CLR  = 'h0C;
    localparam int OFS_DATA = 'h10;
    localparam int OFS_CS   = 'h14;
    localparam int OFS_THR  = 'h18;
endpackage

// File: rtl/sprx_fsm.sv
module sprx_fsm
    import sprx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [EN_W-1:0]     en_field,
    input  logic                wait_act,
    input  logic                ev_activity,
    input  logic                ev_sync_done,
    output logic                accept_ev,
    output logic                accept_data,
    output logic                sync_go,
    output logic                rx_go
);
    sprx_state_e st, nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:     if (en_field != '0) nxt = wait_act ? ST_WAIT_ACT : ST_SYNC;
            ST_WAIT_ACT: if (ev_activity) nxt = ST_SYNC;
            ST_SYNC:     if (ev_sync_done) nxt = ST_LOCKED;
            ST_LOCKED:   if (en_field == 2'b11) nxt = ST_RECV;
            ST_RECV:     if (en_field != 2'b11) nxt = ST_LOCKED;
            default:     nxt = ST_IDLE;
        endcase
        if (en_field == '0) nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        sync_go     = (st == ST_SYNC);
        rx_go       = (st == ST_RECV);
        accept_ev   = (st == ST_SYNC) || (st == ST_LOCKED) || (st == ST_RECV);
        accept_data = (st == ST_RECV);
    end

    p_idle_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_field == '0) |=> (st == ST_IDLE));
    p_recv_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_field != 2'b11) |=> (st != ST_RECV));
    p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT_ACT && !ev_activity && en_field != '0) |=> (st == ST_WAIT_ACT));
endmodule

// File: rtl/sprx_flags.sv
module sprx_flags
    import sprx_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       accept_ev,
    input  logic                       accept_data,
    input  logic [NUM_FLAGS-1:W1C_LO]  evt,
    input  logic                       data_vld,
    input  logic                       cs_vld,
    input  logic                       rd_data,
    input  logic                       rd_cs,
    input  logic                       clr_wr,
    input  logic [W1C_HI:W1C_LO]       clr_val,
    input  logic                       en_off,
    output logic [NUM_FLAGS-1:0]       flags
);
    logic [NUM_FLAGS-1:0] set_v, clr_v;

    assign set_v[FL_DATA] = data_vld & accept_data;
    assign clr_v[FL_DATA] = rd_data;
    assign set_v[FL_CS]   = cs_vld & accept_data;
    assign clr_v[FL_CS]   = rd_cs;

    for (genvar i = W1C_LO; i < NUM_FLAGS; i++) begin : g_evt
        assign set_v[i] = evt[i] & accept_ev;
        if (i <= W1C_HI) begin : g_w1c
            assign clr_v[i] = clr_wr & clr_val[i];
            p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_wr && clr_val[i] && !evt[i]) |=> !flags[i]);
        end else begin : g_err
            assign clr_v[i] = en_off;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_v) | set_v;
    end

    p_rdy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FL_DATA] && !rd_data) |=> flags[FL_DATA]);
    p_err_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_off && !accept_ev) |=> (flags[ERR_HI:ERR_LO] == '0));
endmodule

// File: rtl/sprx_irq.sv
module sprx_irq
    import sprx_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [MASK_W-1:0]    mask,
    output logic                 irq
);
    logic [MASK_GRP-1:0] hit;

    for (genvar i = 0; i < MASK_GRP; i++) begin : g_hit
        assign hit[i] = flags[i] & mask[i];
    end

    assign irq = (|hit) | (mask[MASK_GRP] & (|flags[ERR_HI:ERR_LO]));
endmodule

// File: rtl/sprx_regs.sv
module sprx_regs
    import sprx_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_sync_done,
    input  logic              ev_sync_blk,
    input  logic              ev_parity,
    input  logic              ev_overrun,
    input  logic              ev_frame_err,
    input  logic              ev_sync_err,
    input  logic              ev_timeout,
    input  logic              ev_activity,
    input  logic [DATA_W-1:0] dec_word,
    input  logic              dec_word_vld,
    input  logic [DATA_W-1:0] dec_cs_word,
    input  logic              dec_cs_vld,
    input  logic [DATA_W-1:0] dec_thresh,
    output logic              dec_sync_go,
    output logic              dec_rx_go,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_CS   = ADDR_W'(OFS_CS);
    localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(OFS_THR);

    logic [EN_W-1:0]      ctrl_en;
    logic                 ctrl_wfa;
    logic [MASK_W-1:0]    mask_q;
    logic [DATA_W-1:0]    data_q, cs_q;
    logic [NUM_FLAGS-1:0] flags;
    logic                 accept_ev, accept_data;
    logic [NUM_FLAGS-1:W1C_LO] evt;

    assign evt = {ev_timeout, ev_sync_err, ev_frame_err, ev_sync_done,
                  ev_sync_blk, ev_overrun, ev_parity};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en  <= '0;
            ctrl_wfa <= 1'b0;
            mask_q   <= '0;
            data_q   <= '0;
            cs_q     <= '0;
        end else begin
            if (bus_wr && bus_addr == A_CTRL) begin
                ctrl_en  <= bus_wdata[EN_W-1:0];
                ctrl_wfa <= bus_wdata[CTRL_WFA];
            end
            if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[MASK_W-1:0];
            if (dec_word_vld && accept_data) data_q <= dec_word;
            if (dec_cs_vld && accept_data)   cs_q   <= dec_cs_word;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[EN_W-1:0] = ctrl_en;
                bus_rdata[CTRL_WFA] = ctrl_wfa;
            end
            A_MASK: bus_rdata[MASK_W-1:0]    = mask_q;
            A_STAT: bus_rdata[NUM_FLAGS-1:0] = flags;
            A_DATA: bus_rdata = data_q;
            A_CS:   bus_rdata = cs_q;
            A_THR:  bus_rdata = dec_thresh;
            default: bus_rdata = '0;
        endcase
    end

    sprx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .en_field(ctrl_en), .wait_act(ctrl_wfa),
        .ev_activity(ev_activity), .ev_sync_done(ev_sync_done),
        .accept_ev(accept_ev), .accept_data(accept_data),
        .sync_go(dec_sync_go), .rx_go(dec_rx_go)
    );

    sprx_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .accept_ev(accept_ev), .accept_data(accept_data),
        .evt(evt),
        .data_vld(dec_word_vld), .cs_vld(dec_cs_vld),
        .rd_data(bus_rd && bus_addr == A_DATA),
        .rd_cs(bus_rd && bus_addr == A_CS),
        .clr_wr(bus_wr && bus_addr == A_CLR),
        .clr_val(bus_wdata[W1C_HI:W1C_LO]),
        .en_off(ctrl_en == '0),
        .flags(flags)
    );

    sprx_irq u_irq (.flags(flags), .mask(mask_q), .irq(irq));

    p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0));
    p_rx_needs_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_rx_go) |-> flags[W1C_HI]);
endmodule

// File: tb/tb_sprx_regs.sv
module tb_sprx_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [7:0]  ev = '0;
    logic [31:0] dec_word = '0, dec_cs_word = '0;
    logic        dec_word_vld = 1'b0, dec_cs_vld = 1'b0;
    logic [31:0] dec_thresh = 32'h0ABC_0123;
    logic        dec_sync_go, dec_rx_go, irq;

    int compared = 0, mismatched = 0;
    bit done = 1'b0;

    typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
    item_t sb_q[$];
    event  mon_ev;

    always #10 clk = ~clk;

    sprx_regs dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_sync_done(ev[3]), .ev_sync_blk(ev[2]), .ev_parity(ev[0]),
        .ev_overrun(ev[1]), .ev_frame_err(ev[4]), .ev_sync_err(ev[5]),
        .ev_timeout(ev[6]), .ev_activity(ev[7]),
        .dec_word(dec_word), .dec_word_vld(dec_word_vld),
        .dec_cs_word(dec_cs_word), .dec_cs_vld(dec_cs_vld),
        .dec_thresh(dec_thresh),
        .dec_sync_go(dec_sync_go), .dec_rx_go(dec_rx_go), .irq(irq)
    );

    // monitor: pops expected items and compares with the live outputs
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0: act = bus_rdata;
                    1: act = {31'b0, irq};
                    2: act = {31'b0, dec_sync_go};
                    default: act = {31'b0, dec_rx_go};
                endcase
                compared++;
                if (act !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(int kind, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        -> mon_ev;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [4:0] a, logic [31:0] exp, string tag);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #5 push(0, exp, tag);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic sig_chk(int kind, logic exp, string tag);
        #1 push(kind, {31'b0, exp}, tag);
    endtask

    task automatic pulse(int idx);
        @(negedge clk); ev[idx] = 1'b1;
        @(negedge clk); ev[idx] = 1'b0;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(5'h00, 32'h0, "R1 ctrl reset");
        rd_chk(5'h04, 32'h0, "R1 mask reset");
        rd_chk(5'h08, 32'h0, "R1 status reset");
        sig_chk(1, 1'b0, "R1 irq reset");
        sig_chk(2, 1'b0, "R1 sync_go reset");
        sig_chk(3, 1'b0, "R1 rx_go reset");
        // R4 events ignored in idle
        pulse(0);
        rd_chk(5'h08, 32'h0, "R4 idle ignores parity");
        // R10 read-only status, unmapped, thresholds
        wr(5'h08, 32'hFFFF_FFFF);
        rd_chk(5'h08, 32'h0, "R10 status write ignored");
        rd_chk(5'h1C, 32'h0, "R10 unmapped reads zero");
        rd_chk(5'h18, 32'h0ABC_0123, "R10 thresholds");
        // R2 sync only
        wr(5'h00, 32'h1);
        tick(1);
        sig_chk(2, 1'b1, "R2 sync_go in sync");
        sig_chk(3, 1'b0, "R2 rx_go low in sync");
        rd_chk(5'h00, 32'h1, "R2 ctrl readback");
        // R4 sticky events
        pulse(0); pulse(1); pulse(2);
        rd_chk(5'h08, 32'h1C, "R4 parity/overrun/block set");
        // R5 write-one-to-clear
        wr(5'h0C, 32'h04);
        rd_chk(5'h08, 32'h18, "R5 clear parity only");
        wr(5'h0C, 32'h00);
        rd_chk(5'h08, 32'h18, "R5 zeros no effect");
        wr(5'h0C, 32'h18);
        rd_chk(5'h08, 32'h0, "R5 clear rest");
        // R2 reception needs sync done
        wr(5'h00, 32'h3);
        tick(2);
        sig_chk(3, 1'b0, "R2 no rx before sync done");
        pulse(3);
        tick(1);
        sig_chk(3, 1'b1, "R2 rx_go after sync done");
        sig_chk(2, 1'b0, "R2 sync_go low in recv");
        rd_chk(5'h08, 32'h20, "R4 sync done flag");
        // R6 data ready
        @(negedge clk); dec_word = 32'h00C0_FFEE; dec_word_vld = 1'b1;
        @(negedge clk); dec_word_vld = 1'b0;
        rd_chk(5'h08, 32'h21, "R6 data ready set");
        wr(5'h0C, 32'h1FF);
        rd_chk(5'h08, 32'h01, "R6 clear reg leaves data ready");
        rd_chk(5'h10, 32'h00C0_FFEE, "R6 data word");
        rd_chk(5'h08, 32'h00, "R6 read clears data ready");
        // R7 channel status ready
        @(negedge clk); dec_cs_word = 32'h0123_4567; dec_cs_vld = 1'b1;
        @(negedge clk); dec_cs_vld = 1'b0;
        rd_chk(5'h08, 32'h02, "R7 cs ready set");
        rd_chk(5'h14, 32'h0123_4567, "R7 cs word");
        rd_chk(5'h08, 32'h00, "R7 read clears cs ready");
        // R9 interrupt
        wr(5'h04, 32'h04);
        sig_chk(1, 1'b0, "R9 irq low no flag");
        pulse(0);
        sig_chk(1, 1'b1, "R9 irq on parity");
        wr(5'h0C, 32'h04);
        sig_chk(1, 1'b0, "R9 irq drops on clear");
        wr(5'h04, 32'h40);
        pulse(6);
        sig_chk(1, 1'b1, "R9 grouped mask timeout");
        pulse(4);
        rd_chk(5'h08, 32'h140, "R4 frame and timeout");
        // R8 error bits only cleared by disable
        wr(5'h0C, 32'h1C0);
        rd_chk(5'h08, 32'h140, "R8 clear reg leaves errors");
        wr(5'h00, 32'h0);
        tick(1);
        rd_chk(5'h08, 32'h0, "R8 disable clears errors");
        sig_chk(1, 1'b0, "R8 irq low after disable");
        sig_chk(3, 1'b0, "R8 rx_go low idle");
        // R3 wait for activity
        wr(5'h00, 32'h4001);
        tick(2);
        sig_chk(2, 1'b0, "R3 no sync before activity");
        pulse(5);
        rd_chk(5'h08, 32'h0, "R3 sync error ignored while waiting");
        pulse(7);
        sig_chk(2, 1'b1, "R3 sync after activity");
        pulse(5);
        rd_chk(5'h08, 32'h80, "R3 sync error after activity");
        // R5 event wins over clear
        @(negedge clk); ev[0] = 1'b1; bus_addr = 5'h0C; bus_wdata = 32'h04; bus_wr = 1'b1;
        @(negedge clk); ev[0] = 1'b0; bus_wr = 1'b0;
        rd_chk(5'h08, 32'h84, "R5 event beats clear");
        rd_chk(5'h00, 32'h4001, "R3 ctrl wait bit readback");
        tick(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule